// File: doc/BRIEF.md
# DMA Channel Claim-and-Run Register File

This block is the register front end of one DMA channel. Software reaches it through 32-bit reads and writes inside a 4 KiB window. Software first takes ownership of the channel by setting the claim bit. It then loads a staging set of transfer registers and sets run to launch a transfer. The block checks the request, copies the staging set into a read-only mirror set, and gives the transfer engine a one-cycle start pulse. The engine reports back on a done strobe or an error strobe. The block then updates its status bits, advances or keeps the mirror addresses, and drives separate done and error interrupt lines.

The channel is a three-state machine:
- `CH_FREE`: unclaimed.
- `CH_OWNED`: claimed and idle.
- `CH_ACTIVE`: a transfer is in flight.

The transitions are:
- `FREE->OWNED`: a control write sets claim. This also resets the staging set.
- `OWNED->FREE`: a control write clears claim.
- `OWNED->ACTIVE`: a control write with claim and run set, a nonzero length and matching size fields. This issues the start pulse.
- `ACTIVE->OWNED`: an engine done or error strobe.

A run request that finds a zero length or mismatched sizes stays in `OWNED` and sets a status bit at once.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset the control word reads 0, staging config reads 0x6600_0000, the staging and mirror wide registers read 0, and the start, done-interrupt and error-interrupt outputs are low.
- R2: A control write that sets claim (bit 0) while the channel is unclaimed resets staging. Config becomes 0x6600_0000 (both size fields equal 6) and length, destination and source become 0.
- R3: Run (bit 1) only acts if the channel was already claimed before the write. A write of claim and run together to an unclaimed channel leaves run reading 0 and gives no start pulse.
- R4: In the claimed idle state, a control write with claim and run set, a nonzero length and equal size fields does four things. It gives a start pulse one cycle wide in the cycle after the write. It copies staging into the mirrors at offset+0x100. It clears done (bit 30) and error (bit 31). It leaves run reading 1.
- R5: While a transfer is active, a control write that clears claim leaves claim and run reading 1. Only the interrupt enables (done bit 14, error bit 15) are taken from the write.
- R6: A run request with a zero staging length sets done, leaves run at 0 and issues no start.
- R7: A run request whose write-size field (config bits 27:24) differs from its read-size field (bits 31:28) sets error, leaves run at 0 and issues no start.
- R8: An engine done strobe in the active state clears run and sets done. If the mirror config repeat flag (bit 2) is clear, mirror source and destination advance by the mirror length and the mirror length becomes 0. If the flag is set, all three mirror values stay unchanged.
- R9: An engine error strobe in the active state clears run and sets error. Error takes priority when both strobes come together, and the mirror values stay unchanged.
- R10: The done interrupt equals done-enable AND done status, and the error interrupt equals error-enable AND error status. Both are registered and are re-evaluated on the edge of each control write and each completion.
- R11: Length, destination and source are 64 bits. Each has its low word at its base (0x008, 0x010, 0x018) and its high word at base+4, and each word can be written and read back on its own.
- R12: Writes to the mirror offsets (0x104 to 0x11C) and to unmapped offsets change nothing, and reads of unmapped offsets return 0.
- R13: Engine strobes that arrive while no transfer is active leave the control word and the interrupt lines unchanged.
- R14: A control write that clears claim in the claimed idle state releases the channel (control reads 0). A later run-only write is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| xfer_start | output | 1 | One-cycle launch pulse to the engine |
| xfer_len | output | 64 | Mirror length |
| xfer_dst | output | 64 | Mirror destination |
| xfer_src | output | 64 | Mirror source |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Engine failure strobe |
| irq_done | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Each input is sampled on a rising edge, and its result is due in the cycle that follows:
- Read data is valid one cycle after the read strobe.
- The start pulse, the control word, the mirrors and both interrupt lines change on the same edge that samples the control write or the engine strobe.

The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that must carry the result. The start pulse is checked high at that point and low one cycle later.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
    localparam int REG_AW     = 12;
    localparam int OFS_CTRL   = 'h000;
    localparam int OFS_CFG    = 'h004;
    localparam int OFS_WIDE   = 'h008;
    localparam int OFS_MIRROR = 'h100;

    localparam int CB_CLAIM = 0;
    localparam int CB_RUN   = 1;
    localparam int CB_DIE   = 14;
    localparam int CB_EIE   = 15;
    localparam int CB_DONE  = 30;
    localparam int CB_ERR   = 31;

    localparam int CFG_REPEAT = 2;
    localparam int CFG_WSZ_LO = 24;
    localparam int CFG_RSZ_LO = 28;

    typedef enum logic [1:0] {CH_FREE, CH_OWNED, CH_ACTIVE} ch_state_e;

    typedef struct packed {
        logic err;
        logic done;
        logic eie;
        logic die;
        logic run;
        logic claim;
    } ctrl_t;

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CB_CLAIM] = c.claim;
        w[CB_RUN]   = c.run;
        w[CB_DIE]   = c.die;
        w[CB_EIE]   = c.eie;
        w[CB_DONE]  = c.done;
        w[CB_ERR]   = c.err;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.claim = w[CB_CLAIM];
        c.run   = w[CB_RUN];
        c.die   = w[CB_DIE];
        c.eie   = w[CB_EIE];
        c.done  = w[CB_DONE];
        c.err   = w[CB_ERR];
        return c;
    endfunction
endpackage

// File: rtl/dma_chan_fsm.sv
`timescale 1ns/1ps
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ctrl,
    input  ctrl_t wr_val,
    input  logic  len_zero,
    input  logic  size_bad,
    input  logic  eng_done,
    input  logic  eng_err,
    output ctrl_t ctrl,
    output logic  launch,
    output logic  start,
    output logic  stage_reset,
    output logic  finish_ok,
    output logic  irq_done,
    output logic  irq_err
);
    ch_state_e st_q, st_d;
    ctrl_t     c_q, c_d;
    logic      start_q, start_d;
    logic      eval;
    logic      irq_done_q, irq_err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= CH_FREE;
            c_q     <= '0;
            start_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            c_q     <= c_d;
            start_q <= start_d;
        end
    end

    // next state and control word
    always_comb begin
        st_d        = st_q;
        c_d         = c_q;
        start_d     = 1'b0;
        eval        = 1'b0;
        stage_reset = 1'b0;
        finish_ok   = 1'b0;
        unique case (st_q)
            CH_FREE: begin
                if (wr_ctrl) begin
                    eval    = 1'b1;
                    c_d     = wr_val;
                    c_d.run = 1'b0;
                    if (wr_val.claim) begin
                        stage_reset = 1'b1;
                        st_d        = CH_OWNED;
                    end
                end
            end
            CH_OWNED: begin
                if (wr_ctrl) begin
                    eval    = 1'b1;
                    c_d     = wr_val;
                    c_d.run = 1'b0;
                    if (!wr_val.claim) begin
                        st_d = CH_FREE;
                    end else if (wr_val.run) begin
                        if (len_zero) begin
                            c_d.done = 1'b1;
                        end else if (size_bad) begin
                            c_d.err = 1'b1;
                        end else begin
                            c_d.run  = 1'b1;
                            c_d.done = 1'b0;
                            c_d.err  = 1'b0;
                            start_d  = 1'b1;
                            st_d     = CH_ACTIVE;
                        end
                    end
                end
            end
            CH_ACTIVE: begin
                if (wr_ctrl) begin
                    eval    = 1'b1;
                    c_d.die = wr_val.die;
                    c_d.eie = wr_val.eie;
                end
                if (eng_done || eng_err) begin
                    eval      = 1'b1;
                    c_d.run   = 1'b0;
                    c_d.err   = eng_err;
                    c_d.done  = !eng_err;
                    finish_ok = !eng_err;
                    st_d      = CH_OWNED;
                end
            end
            default: st_d = CH_FREE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_done_q <= 1'b0;
            irq_err_q  <= 1'b0;
        end else if (eval) begin
            irq_done_q <= c_d.die & c_d.done;
            irq_err_q  <= c_d.eie & c_d.err;
        end
    end

    assign ctrl     = c_q;
    assign launch   = start_d;
    assign start    = start_q;
    assign irq_done = irq_done_q;
    assign irq_err  = irq_err_q;

    assert_start_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (st_q == CH_ACTIVE && c_q.claim && c_q.run));
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    assert_no_start_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FREE) |=> !start_q);
    assert_claim_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ACTIVE && wr_ctrl && !wr_val.claim && !eng_done && !eng_err)
        |=> (c_q.claim && c_q.run));
    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_q == (c_q.die && c_q.done));
    assert_irq_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err_q == (c_q.eie && c_q.err));
    assert_stray_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CH_ACTIVE && !wr_ctrl) |=> $stable(c_q));
endmodule

// File: rtl/dma_chan_xfer_regs.sv
`timescale 1ns/1ps
module dma_chan_xfer_regs
    import dma_chan_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = REG_AW,
    parameter int WIDE_N = 3,
    parameter int SZ_DEF = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            stage_reset,
    input  logic            load,
    input  logic            advance,
    output logic [DW-1:0]   rd_val,
    output logic            len_zero,
    output logic            size_bad,
    output logic            rep,
    output logic [2*DW-1:0] xfer_len,
    output logic [2*DW-1:0] xfer_dst,
    output logic [2*DW-1:0] xfer_src
);
    localparam int WW = 2 * DW;
    localparam logic [DW-1:0] CFG_DEF =
        (DW'(SZ_DEF) << CFG_RSZ_LO) | (DW'(SZ_DEF) << CFG_WSZ_LO);

    logic [DW-1:0] cfg_st_q, cfg_mi_q;
    logic [WIDE_N-1:0][WW-1:0] st_w, mi_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_st_q <= CFG_DEF;
            cfg_mi_q <= '0;
        end else begin
            if (stage_reset)
                cfg_st_q <= CFG_DEF;
            else if (wr && addr == AW'(OFS_CFG))
                cfg_st_q <= wdata;
            if (load)
                cfg_mi_q <= cfg_st_q;
        end
    end

    // slot 0 = length, 1 = destination, 2 = source
    for (genvar i = 0; i < WIDE_N; i++) begin : g_wide
        localparam int BASE = OFS_WIDE + 8 * i;
        logic [WW-1:0] s_q, m_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                s_q <= '0;
            else if (stage_reset)
                s_q <= '0;
            else if (wr && addr == AW'(BASE))
                s_q[DW-1:0] <= wdata;
            else if (wr && addr == AW'(BASE + 4))
                s_q[WW-1:DW] <= wdata;
        end

        if (i == 0) begin : g_len
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       m_q <= '0;
                else if (load)    m_q <= s_q;
                else if (advance) m_q <= '0;
            end
        end else begin : g_ptr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       m_q <= '0;
                else if (load)    m_q <= s_q;
                else if (advance) m_q <= m_q + mi_w[0];
            end
        end

        assign st_w[i] = s_q;
        assign mi_w[i] = m_q;
    end

    always_comb begin
        rd_val = '0;
        if (addr == AW'(OFS_CFG))              rd_val = cfg_st_q;
        if (addr == AW'(OFS_CFG + OFS_MIRROR)) rd_val = cfg_mi_q;
        for (int i = 0; i < WIDE_N; i++) begin
            if (addr == AW'(OFS_WIDE + 8 * i))                  rd_val = st_w[i][DW-1:0];
            if (addr == AW'(OFS_WIDE + 8 * i + 4))              rd_val = st_w[i][WW-1:DW];
            if (addr == AW'(OFS_WIDE + 8 * i + OFS_MIRROR))     rd_val = mi_w[i][DW-1:0];
            if (addr == AW'(OFS_WIDE + 8 * i + 4 + OFS_MIRROR)) rd_val = mi_w[i][WW-1:DW];
        end
    end

    assign len_zero = (st_w[0] == '0);
    assign size_bad = cfg_st_q[CFG_WSZ_LO +: 4] != cfg_st_q[CFG_RSZ_LO +: 4];
    assign rep      = cfg_mi_q[CFG_REPEAT];
    assign xfer_len = mi_w[0];
    assign xfer_dst = mi_w[1];
    assign xfer_src = mi_w[2];

    assert_claim_defaults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stage_reset |=> (cfg_st_q == CFG_DEF && st_w == '0));
    assert_mirror_ro_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(mi_w) && $stable(cfg_mi_q)));
    assert_len_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (mi_w[0] == '0));
endmodule

// File: rtl/dma_chan_regfile.sv
`timescale 1ns/1ps
module dma_chan_regfile
    import dma_chan_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              xfer_start,
    output logic [2*DW-1:0]   xfer_len,
    output logic [2*DW-1:0]   xfer_dst,
    output logic [2*DW-1:0]   xfer_src,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              irq_done,
    output logic              irq_err
);
    logic          wr_ctrl;
    ctrl_t         wr_val, ctrl;
    logic          launch, stage_reset, finish_ok;
    logic          len_zero, size_bad, rep;
    logic [DW-1:0] x_rd, rdata_q;

    assign wr_ctrl = bus_wr && (bus_addr == REG_AW'(OFS_CTRL));
    assign wr_val  = word_to_ctrl(bus_wdata);

    dma_chan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_val      (wr_val),
        .len_zero    (len_zero),
        .size_bad    (size_bad),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .ctrl        (ctrl),
        .launch      (launch),
        .start       (xfer_start),
        .stage_reset (stage_reset),
        .finish_ok   (finish_ok),
        .irq_done    (irq_done),
        .irq_err     (irq_err)
    );

    dma_chan_xfer_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .stage_reset (stage_reset),
        .load        (launch),
        .advance     (finish_ok && !rep),
        .rd_val      (x_rd),
        .len_zero    (len_zero),
        .size_bad    (size_bad),
        .rep         (rep),
        .xfer_len    (xfer_len),
        .xfer_dst    (xfer_dst),
        .xfer_src    (xfer_src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (bus_rd)
            rdata_q <= (bus_addr == REG_AW'(OFS_CTRL)) ? ctrl_to_word(ctrl) : x_rd;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: tb/sim_dma_chan_regfile.sv
`timescale 1ns/1ps
module sim_dma_chan_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xfer_start;
    logic [63:0] xfer_len, xfer_dst, xfer_src;
    logic        eng_done = 1'b0, eng_err = 1'b0;
    logic        irq_done, irq_err;
    int          n_chk = 0, n_fail = 0;
    bit          ended = 1'b0;

    always #2 clk = ~clk;

    dma_chan_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_dst(xfer_dst),
        .xfer_src(xfer_src), .eng_done(eng_done), .eng_err(eng_err),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic eng(logic dn, logic er);
        @(negedge clk); eng_done = dn; eng_err = er;
        @(negedge clk); eng_done = 1'b0; eng_err = 1'b0;
    endtask

    task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic t_reset();
        chk("R1 start", {63'h0, xfer_start}, 64'h0);
        chk("R1 irq", {62'h0, irq_done, irq_err}, 64'h0);
        rchk("R1 ctrl", 12'h000, 32'h0);
        rchk("R1 cfg", 12'h004, 32'h6600_0000);
        rchk("R1 len", 12'h008, 32'h0);
        rchk("R1 mirror src", 12'h118, 32'h0);
    endtask

    task automatic t_unclaimed_run();
        wr(12'h000, 32'h3);
        chk("R3 no start", {63'h0, xfer_start}, 64'h0);
        rchk("R3 run clear", 12'h000, 32'h1);
    endtask

    task automatic t_release();
        wr(12'h008, 32'h55);
        wr(12'h000, 32'h0);
        rchk("R14 released", 12'h000, 32'h0);
        wr(12'h000, 32'h2);
        chk("R14 no start", {63'h0, xfer_start}, 64'h0);
        rchk("R14 run ignored", 12'h000, 32'h0);
        wr(12'h004, 32'h1234_0000);
        wr(12'h000, 32'h1);
        rchk("R2 cfg default", 12'h004, 32'h6600_0000);
        rchk("R2 len zero", 12'h008, 32'h0);
    endtask

    task automatic t_wide();
        wr(12'h008, 32'hAAAA_0001);
        wr(12'h00C, 32'h0000_00BB);
        rchk("R11 len lo", 12'h008, 32'hAAAA_0001);
        rchk("R11 len hi", 12'h00C, 32'h0000_00BB);
        wr(12'h014, 32'h7);
        rchk("R11 dst hi", 12'h014, 32'h7);
        rchk("R11 dst lo", 12'h010, 32'h0);
    endtask

    task automatic t_run_done();
        wr(12'h008, 32'h100); wr(12'h00C, 32'h0);
        wr(12'h010, 32'h2000); wr(12'h014, 32'h0);
        wr(12'h018, 32'h1000);
        wr(12'h000, 32'h4003);
        chk("R4 start high", {63'h0, xfer_start}, 64'h1);
        chk("R4 len out", xfer_len, 64'h100);
        chk("R4 src out", xfer_src, 64'h1000);
        @(negedge clk);
        chk("R4 start one cycle", {63'h0, xfer_start}, 64'h0);
        rchk("R4 ctrl running", 12'h000, 32'h4003);
        rchk("R4 mirror dst", 12'h110, 32'h2000);
        wr(12'h000, 32'h4000);
        rchk("R5 claim held", 12'h000, 32'h4003);
        wr(12'h108, 32'hDEAD);
        rchk("R12 mirror ro", 12'h108, 32'h100);
        wr(12'h040, 32'hFFFF_FFFF);
        rchk("R12 unmapped", 12'h040, 32'h0);
        eng(1'b1, 1'b0);
        chk("R10 irq_done", {63'h0, irq_done}, 64'h1);
        chk("R10 irq_err low", {63'h0, irq_err}, 64'h0);
        rchk("R8 ctrl done", 12'h000, 32'h4000_4001);
        rchk("R8 src advanced", 12'h118, 32'h1100);
        rchk("R8 dst advanced", 12'h110, 32'h2100);
        rchk("R8 len zero", 12'h108, 32'h0);
        eng(1'b0, 1'b1);
        rchk("R13 ctrl unchanged", 12'h000, 32'h4000_4001);
        chk("R13 irq_err low", {63'h0, irq_err}, 64'h0);
        wr(12'h000, 32'h1);
        chk("R10 irq_done cleared", {63'h0, irq_done}, 64'h0);
    endtask

    task automatic t_repeat_err();
        wr(12'h004, 32'h6600_0004);
        wr(12'h008, 32'h40); wr(12'h018, 32'h3000);
        wr(12'h000, 32'h8003);
        chk("R4 start repeat", {63'h0, xfer_start}, 64'h1);
        eng(1'b1, 1'b1);
        chk("R9 irq_err", {63'h0, irq_err}, 64'h1);
        chk("R9 irq_done low", {63'h0, irq_done}, 64'h0);
        rchk("R9 ctrl err", 12'h000, 32'h8000_8001);
        rchk("R9 mirror kept", 12'h118, 32'h3000);
        wr(12'h000, 32'h3);
        chk("R10 irq_err cleared", {63'h0, irq_err}, 64'h0);
        eng(1'b1, 1'b0);
        rchk("R8 repeat src", 12'h118, 32'h3000);
        rchk("R8 repeat len", 12'h108, 32'h40);
    endtask

    task automatic t_zero_len();
        wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
        wr(12'h000, 32'h4003);
        chk("R6 no start", {63'h0, xfer_start}, 64'h0);
        chk("R6 irq_done", {63'h0, irq_done}, 64'h1);
        rchk("R6 ctrl", 12'h000, 32'h4000_4001);
    endtask

    task automatic t_mismatch();
        wr(12'h008, 32'h80);
        wr(12'h004, 32'h6500_0000);
        wr(12'h000, 32'h8003);
        chk("R7 no start", {63'h0, xfer_start}, 64'h0);
        chk("R7 irq_err", {63'h0, irq_err}, 64'h1);
        rchk("R7 ctrl", 12'h000, 32'h8000_8001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unclaimed_run();
        t_release();
        t_wide();
        t_run_done();
        t_repeat_err();
        t_zero_len();
        t_mismatch();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule